// File: doc/BRIEF.md
# Serial Slave Front End with Transfer Pause

This block is the serial receive and transmit front end of a small multi-channel control device. A host talks to it over a four-wire serial bus in clock mode 0 or mode 3, with an active-low chip select. The block brings the bus pins into the system clock domain and finds their edges there. It shifts in bits on rising serial clock edges and assembles them into bytes. It then passes each byte to a command layer, together with strobes that mark the start of a frame, its end and its abandonment. For reads it shifts out, MSB first, the bytes that the command layer places on its transmit input.

The first byte of every frame is a header. Its top two bits carry a device address, and these are compared with two strap inputs, so that four devices can share one bus. A frame whose address does not match is dropped. The block raises an abort strobe, delivers nothing more, and never enables its serial output during that frame. An active-low pause input lets the host freeze a transfer at any bit and resume it later without resending anything. While paused, the serial output is released and the serial input and serial clock are ignored.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, rx_valid, frame_start, frame_end, frame_whole, frame_abort and spi_miso_oe are all 0.
- R2: Nothing is accepted until a falling edge of spi_csn is seen. That falling edge produces a one-clock frame_start. All strobes and spi_miso_oe change on the clock edge SYNC_STAGES+1 edges after the causing pin change.
- R3: Bits on spi_mosi are captured on rising spi_sck edges and assembled MSB first. Each completed byte is presented on rx_byte with a one-clock rx_valid. rx_first is 1 only for the header byte.
- R4: Header bits [7:6] are compared with dev_strap. On a mismatch, frame_abort pulses once, no rx_valid or frame_end follows for that frame, and spi_miso_oe stays 0.
- R5: After a matching header, on the spi_sck falling edge that follows each completed byte, tx_byte is loaded and its bit 7 is placed on spi_miso. Each further falling edge within the byte shifts out the next bit. spi_miso_oe is 1 only while the frame is selected, matched and not paused.
- R6: Mode 3 (serial clock idling high) works like mode 0. A falling edge before the first rising edge of a byte shifts nothing.
- R7: The pause engages only when spi_hold_n is low while the synchronised spi_sck is low. While paused, spi_miso_oe is 0 and spi_sck and spi_mosi transitions have no effect.
- R8: Raising spi_hold_n while spi_sck is low resumes the transfer at the same bit position, in both directions.
- R9: A rising edge of spi_csn ends a selected, non-aborted frame with a one-clock frame_end. frame_whole is 1 in that clock only if at least one byte arrived and no partial byte is pending.
- R10: rx_valid, frame_start, frame_end and frame_abort are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Transfer pause, active low |
| dev_strap | input | ADDR_W | Device address straps |
| tx_byte | input | DATA_W | Next byte to send, from the command layer |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 means floating) |
| rx_valid | output | 1 | One-clock strobe: rx_byte holds a new byte |
| rx_byte | output | DATA_W | Received byte |
| rx_first | output | 1 | rx_byte is the frame header |
| frame_start | output | 1 | One-clock strobe on frame selection |
| frame_end | output | 1 | One-clock strobe on frame deselection |
| frame_whole | output | 1 | With frame_end: only whole bytes were received |
| frame_abort | output | 1 | One-clock strobe on address mismatch |

## Verification
Two events can land in the same system clock: a serial clock falling edge that loads or shifts the transmit byte, and the pause taking hold. The bench provokes this by dropping spi_hold_n in the same clock as spi_sck falls, including on the edge right after a byte completes. The load must still take effect, the output must then float, and after the pause the host must read the loaded byte intact. A behavioural model in the bench predicts every strobe, the output enable and the output bit on every clock, and host-level checks compare the bytes each side received.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int PIN_N   = 4;
  localparam int P_CSN   = 0;
  localparam int P_SCK   = 1;
  localparam int P_MOSI  = 2;
  localparam int P_HOLDN = 3;
  localparam int EDGE_N  = 2;
  // idle bus: chip select and pause released, clock and data low
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

  function automatic logic field_match(input logic [7:0] hdr, input logic [1:0] strap);
    return hdr[7:6] == strap;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter int EDGE_W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      lvl_o,
  output logic [EDGE_W-1:0] prv_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [EDGE_W-1:0]        prv_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= RST_VAL;
        else     chain_q[0] <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prv_q <= RST_VAL[EDGE_W-1:0];
    else     prv_q <= chain_q[STAGES-1][EDGE_W-1:0];
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser #(
  parameter int DATA_W = 8,
  parameter int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign word_o = {sh_q[DATA_W-2:0], din};
  assign done_o = en && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= word_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R8: without a capture enable the bit position is frozen (pause keeps position)
  assert_pos_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_tx_ser.sv
module spi_tx_ser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  sh_q <= '0;
    else if (load)   sh_q <= din;
    else if (shift)  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[DATA_W-1];
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int ADDR_LSB = DATA_W - ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_hold_n,
  input  logic [ADDR_W-1:0] dev_strap,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_whole,
  output logic              frame_abort
);
  import spi_hold_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  logic [PIN_N-1:0]  pin_vec, lvl;
  logic [EDGE_N-1:0] prv;
  logic cs_fall, cs_rise, sck_rise, sck_fall, cs_evt, live;
  logic rx_en, rx_done, tx_load, tx_shift, addr_ok, tx_bit;
  logic [CNT_W-1:0]  bit_pos;
  logic [DATA_W-1:0] word;

  logic active_q, hold_q, first_q, matched_q, mism_q;
  logic rx_valid_q, rx_first_q, start_q, end_q, whole_q, abort_q;
  logic [DATA_W-1:0] rx_byte_q;

  assign pin_vec = {spi_hold_n, spi_mosi, spi_sck, spi_csn};

  spi_pin_sync #(.W(PIN_N), .EDGE_W(EDGE_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_vec), .lvl_o(lvl), .prv_o(prv)
  );

  assign cs_fall  =  prv[P_CSN] & ~lvl[P_CSN];
  assign cs_rise  = ~prv[P_CSN] &  lvl[P_CSN];
  assign sck_rise = ~prv[P_SCK] &  lvl[P_SCK];
  assign sck_fall =  prv[P_SCK] & ~lvl[P_SCK];
  assign cs_evt   = cs_fall | cs_rise;

  // shifting allowed only inside a live, unpaused, non-rejected frame
  assign live     = active_q & ~cs_evt & ~hold_q & ~mism_q;
  assign rx_en    = live & sck_rise;
  assign tx_shift = live & sck_fall & (bit_pos != '0);
  assign tx_load  = live & sck_fall & (bit_pos == '0) & matched_q;

  spi_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .clr(cs_fall), .en(rx_en), .din(lvl[P_MOSI]),
    .cnt_o(bit_pos), .done_o(rx_done), .word_o(word)
  );

  spi_tx_ser #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .clr(cs_fall), .load(tx_load), .shift(tx_shift),
    .din(tx_byte), .bit_o(tx_bit)
  );

  generate
    if (DATA_W == 8 && ADDR_W == 2 && ADDR_LSB == 6) begin : g_fn_match
      assign addr_ok = field_match(word, dev_strap);
    end else begin : g_gen_match
      assign addr_ok = (word[ADDR_LSB +: ADDR_W] == dev_strap);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      hold_q     <= 1'b0;
      first_q    <= 1'b0;
      matched_q  <= 1'b0;
      mism_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_first_q <= 1'b0;
      rx_byte_q  <= '0;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
      whole_q    <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
      whole_q    <= 1'b0;
      abort_q    <= 1'b0;
      if (cs_rise) begin
        if (active_q && !mism_q) begin
          end_q   <= 1'b1;
          whole_q <= (bit_pos == '0) && !first_q;
        end
        active_q  <= 1'b0;
        hold_q    <= 1'b0;
        first_q   <= 1'b0;
        matched_q <= 1'b0;
        mism_q    <= 1'b0;
      end else if (cs_fall) begin
        active_q  <= 1'b1;
        start_q   <= 1'b1;
        first_q   <= 1'b1;
        matched_q <= 1'b0;
        mism_q    <= 1'b0;
        hold_q    <= 1'b0;
      end else if (active_q) begin
        if (!lvl[P_SCK]) hold_q <= ~lvl[P_HOLDN];
        if (rx_done) begin
          if (first_q) begin
            first_q <= 1'b0;
            if (addr_ok) begin
              matched_q  <= 1'b1;
              rx_valid_q <= 1'b1;
              rx_first_q <= 1'b1;
              rx_byte_q  <= word;
            end else begin
              mism_q  <= 1'b1;
              abort_q <= 1'b1;
            end
          end else begin
            rx_valid_q <= 1'b1;
            rx_first_q <= 1'b0;
            rx_byte_q  <= word;
          end
        end
      end
    end
  end

  assign spi_miso    = tx_bit;
  assign spi_miso_oe = active_q & matched_q & ~hold_q;
  assign rx_valid    = rx_valid_q;
  assign rx_byte     = rx_byte_q;
  assign rx_first    = rx_first_q;
  assign frame_start = start_q;
  assign frame_end   = end_q;
  assign frame_whole = whole_q;
  assign frame_abort = abort_q;

  // R10: upward strobes are exclusive
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid_q, start_q, end_q, abort_q}));
  // R2: bytes are delivered only inside a selected frame
  assert_rx_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_q |-> active_q);
  // R4: a rejected frame yields no data and no end
  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    mism_q |=> (!rx_valid_q && !end_q));
  // R5: output is driven only once the header has been accepted
  assert_oe_after_hdr_R5: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> !first_q);
  // R7: no byte completes while paused
  assert_pause_no_rx_R7: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !rx_valid_q);
  // R9: the whole-bytes flag qualifies only a frame end
  assert_whole_with_end_R9: assert property (@(posedge clk) disable iff (rst)
    whole_q |-> end_q);
endmodule

// File: tb/spi_hold_slave_tb_top.sv
module spi_hold_slave_tb_top;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int SYNC = 2;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic csn = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic [AW-1:0] strap = 2'b10;
  logic [DW-1:0] tx_byte = '0;
  logic miso, miso_oe, rx_valid, rx_first, f_start, f_end, f_whole, f_abort;
  logic [DW-1:0] rx_byte;

  spi_hold_slave #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .dev_strap(strap), .tx_byte(tx_byte),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_first(rx_first), .frame_start(f_start), .frame_end(f_end),
    .frame_whole(f_whole), .frame_abort(f_abort)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] ph [0:SYNC+1];
  logic [3:0] cur, prv;
  bit m_act, m_hold, m_first, m_match, m_mism, h_old;
  int m_cnt;
  logic [7:0] m_sh, m_tx, nb;
  bit e_rxv, e_first, e_start, e_end, e_whole, e_abort;
  logic [7:0] e_byte;

  always @(posedge clk) begin
    e_rxv = 0; e_start = 0; e_end = 0; e_whole = 0; e_abort = 0;
    if (rst) begin
      for (int i = 0; i <= SYNC + 1; i++) ph[i] = 4'b1001;
      m_act = 0; m_hold = 0; m_first = 0; m_match = 0; m_mism = 0;
      m_cnt = 0; m_sh = 0; m_tx = 0; e_first = 0; e_byte = 0;
    end else begin
      for (int i = SYNC + 1; i > 0; i--) ph[i] = ph[i-1];
      ph[0] = {hold_n, mosi, sck, csn};
      cur = ph[SYNC]; prv = ph[SYNC+1];
      if (!prv[0] && cur[0]) begin
        if (m_act && !m_mism) begin
          e_end = 1;
          e_whole = (m_cnt == 0) && !m_first;
        end
        m_act = 0; m_hold = 0; m_first = 0; m_match = 0; m_mism = 0;
      end else if (prv[0] && !cur[0]) begin
        m_act = 1; e_start = 1; m_first = 1; m_match = 0; m_mism = 0; m_hold = 0;
        m_cnt = 0; m_sh = 0; m_tx = 0;
      end else if (m_act) begin
        h_old = m_hold;
        if (!cur[1]) m_hold = !cur[3];
        if (!h_old && !m_mism) begin
          if (!prv[1] && cur[1]) begin
            nb = {m_sh[6:0], cur[2]};
            m_sh = nb;
            if (m_cnt == 7) begin
              m_cnt = 0;
              if (m_first) begin
                m_first = 0;
                if (nb[7:6] == strap) begin
                  m_match = 1; e_rxv = 1; e_first = 1; e_byte = nb;
                end else begin
                  m_mism = 1; e_abort = 1;
                end
              end else begin
                e_rxv = 1; e_first = 0; e_byte = nb;
              end
            end else m_cnt++;
          end else if (prv[1] && !cur[1]) begin
            if (m_cnt != 0) m_tx = m_tx << 1;
            else if (m_match) m_tx = tx_byte;
          end
        end
      end
    end
  end

  // ---------------- per-clock comparison and monitors ----------------
  logic [7:0] rxq [$];
  int n_start = 0, n_end = 0, n_abort = 0;
  bit last_whole = 0, oe_seen = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(rx_valid == e_rxv, "R3", "rx_valid", rx_valid, e_rxv);
      if (e_rxv) begin
        check(rx_byte == e_byte, "R3", "rx_byte", rx_byte, e_byte);
        check(rx_first == e_first, "R3", "rx_first", rx_first, e_first);
      end
      check(f_start == e_start, "R2", "frame_start", f_start, e_start);
      check(f_end == e_end, "R9", "frame_end", f_end, e_end);
      if (e_end) check(f_whole == e_whole, "R9", "frame_whole", f_whole, e_whole);
      check(f_abort == e_abort, "R4", "frame_abort", f_abort, e_abort);
      check(miso_oe == (m_act && m_match && !m_hold), "R5", "miso_oe", miso_oe, m_act && m_match && !m_hold);
      if (miso_oe) check(miso == m_tx[7], "R5", "miso bit", miso, m_tx[7]);
      if (rx_valid) begin
        rxq.push_back(rx_byte);
        tx_byte <= rx_byte ^ 8'h3C;
      end
      if (f_start) n_start++;
      if (f_end) begin n_end++; last_whole = f_whole; end
      if (f_abort) n_abort++;
      if (miso_oe) oe_seen = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- host tasks ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] fb [4];
  logic [7:0] got [4];

  task automatic do_pause();
    tick(8);
    check(miso_oe == 0, "R7", "oe while paused", miso_oe, 0);
    repeat (2) begin
      mosi = ~mosi; sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
    check(miso_oe == 0, "R7", "oe after ignored toggles", miso_oe, 0);
    hold_n = 1'b1;
    tick(8);
    check(miso_oe == 1, "R8", "oe after resume", miso_oe, 1);
  endtask

  task automatic frame(input bit m3, input int n, input bit exp_match,
                       input int hb, input int hbit, input bit same);
    int s0, e0, a0;
    bit hit;
    s0 = n_start; e0 = n_end; a0 = n_abort;
    rxq.delete(); oe_seen = 0;
    sck = m3; tick(4);
    csn = 1'b0; tick(HP);
    for (int k = 0; k < n; k++) begin
      for (int i = DW - 1; i >= 0; i--) begin
        hit = (k == hb) && (i == hbit) && !m3;
        if (m3) sck = 1'b0;
        mosi = fb[k][i];
        tick(HP);
        sck = 1'b1;
        got[k][i] = miso;
        if (hit && !same) begin
          tick(2); hold_n = 1'b0; tick(4);
          check(miso_oe == 1, "R7", "no pause while sck high", miso_oe, 1);
        end else tick(HP);
        if (!m3) begin
          sck = 1'b0;
          if (hit && same) hold_n = 1'b0;
          if (hit) do_pause();
        end
      end
    end
    tick(HP);
    csn = 1'b1;
    tick(2 * HP);
    sck = 1'b0; tick(4);
    check(n_start == s0 + 1, "R2", "frame_start count", n_start - s0, 1);
    if (exp_match) begin
      check(rxq.size() == n, "R3", "bytes received", rxq.size(), n);
      for (int k = 0; k < n && k < rxq.size(); k++)
        check(rxq[k] == fb[k], "R3", "byte value", rxq[k], fb[k]);
      for (int k = 1; k < n; k++)
        check(got[k] == (fb[k-1] ^ 8'h3C), m3 ? "R6" : (hb >= 0 ? "R8" : "R5"),
              "host read byte", got[k], fb[k-1] ^ 8'h3C);
      check(n_end == e0 + 1, "R9", "frame_end count", n_end - e0, 1);
      check(last_whole == 1, "R9", "whole flag", last_whole, 1);
    end else begin
      check(rxq.size() == 0, "R4", "bytes after mismatch", rxq.size(), 0);
      check(n_abort == a0 + 1, "R4", "abort count", n_abort - a0, 1);
      check(n_end == e0, "R4", "end after mismatch", n_end - e0, 0);
      check(oe_seen == 0, "R4", "oe during rejected frame", oe_seen, 0);
    end
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    check(rx_valid == 0 && f_start == 0 && f_end == 0 && f_abort == 0 && f_whole == 0,
          "R1", "strobes after reset", {rx_valid, f_start, f_end, f_abort, f_whole}, 0);
    check(miso_oe == 0, "R1", "oe after reset", miso_oe, 0);

    // R2: clock activity without selection is ignored
    repeat (3) begin sck = 1'b1; mosi = ~mosi; tick(HP); sck = 1'b0; tick(HP); end
    check(n_start == 0 && rxq.size() == 0, "R2", "activity while deselected", n_start, 0);

    // R3 R5: mode 0, matching header
    fb[0] = 8'h95; fb[1] = 8'h5A; fb[2] = 8'hC3;
    frame(1'b0, 3, 1'b1, -1, 0, 1'b0);

    // R6: mode 3
    fb[0] = 8'hA1; fb[1] = 8'h0F; fb[2] = 8'hE7; fb[3] = 8'h66;
    frame(1'b1, 4, 1'b1, -1, 0, 1'b0);

    // R4: mismatching header
    fb[0] = 8'h55; fb[1] = 8'hFF;
    frame(1'b0, 2, 1'b0, -1, 0, 1'b0);

    // R7 R8: pause mid-byte, engaged by the falling edge after hold_n went low
    fb[0] = 8'h8E; fb[1] = 8'h39; fb[2] = 8'hD2;
    frame(1'b0, 3, 1'b1, 1, 4, 1'b0);

    // R7 R8: pause in the same clock as the load edge after a byte
    fb[0] = 8'hBB; fb[1] = 8'h71; fb[2] = 8'h2C;
    frame(1'b0, 3, 1'b1, 1, 0, 1'b1);

    // R4: other strap value
    strap = 2'b01;
    fb[0] = 8'h47; fb[1] = 8'hA9;
    frame(1'b0, 2, 1'b1, -1, 0, 1'b0);
    fb[0] = 8'hC7;
    frame(1'b1, 1, 1'b0, -1, 0, 1'b0);

    // R9: partial trailing byte
    begin
      int e0;
      e0 = n_end; rxq.delete();
      sck = 1'b0; tick(4); csn = 1'b0; tick(HP);
      for (int i = 0; i < 11; i++) begin
        mosi = (i < 8) ? 8'h52 >> (7 - i) : 1'b1;
        tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
      end
      tick(HP); csn = 1'b1; tick(2 * HP);
      check(n_end == e0 + 1, "R9", "partial frame end", n_end - e0, 1);
      check(last_whole == 0, "R9", "partial whole flag", last_whole, 0);
      check(rxq.size() == 1, "R3", "partial frame bytes", rxq.size(), 1);
    end

    // R9: deselect before any byte
    begin
      int e0;
      e0 = n_end;
      csn = 1'b0; tick(3 * HP); csn = 1'b1; tick(2 * HP);
      check(n_end == e0 + 1 && last_whole == 0, "R9", "empty frame whole", last_whole, 0);
    end

    tick(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule